// File: doc/BRIEF.md
# FIFO-Gated Read Burst Planner

This block decides when a DMA-style read master may open a bus access that fills a local data FIFO, and which burst the access uses. Software first sets up a transfer: a start byte address, a length in 32-bit words, a maximum burst setting, a flag that allows only defined-length bursts, and a select bit for one of two master ports. The planner then watches the FIFO free-space count. Each time enough room has opened up, it presents one request. The request carries an AHB HBURST code, a beat count, the byte address of the first beat and the port index.

A request stays on the outputs until the bus side acknowledges it. The planner then moves its address and remaining count past the words that request covered, and plans the next piece. This repeats until the transfer length is used up. Burst sizes are picked largest first. A size is cut back by the words left, by the free space, and by the distance to the next 1 KB address boundary. A leftover piece of two or three words becomes either one undefined-length INCR burst or a run of SINGLE transfers, depending on the defined-length flag.

Top module: `ahb_burst_planner`

## Requirements
- R1: After reset, `busy`, `req_valid` and `req_port` are 0, and the latched configuration is all zero: a one-word start threshold, undefined-length INCR allowed, port 0.
- R2: The setting `cfg_blen` gives the start threshold in words: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. A request is raised only when `fifo_free` is at least that threshold, or at least the remaining words if fewer words remain.
- R3: When fewer words remain than the threshold, a request starts once `fifo_free` reaches the remaining count, so the tail of a transfer never waits for a full threshold.
- R4: The beat count is the largest allowed size that fits within the remaining words, the free space and the words left before the boundary. Sizes are tried in the order 16, 8, 4, then 2 or 3, then 1.
- R5: INCR16 is allowed only for setting 3. INCR8 is allowed for settings 2 and 3. INCR4 is allowed for settings 1 to 3. SINGLE is always allowed.
- R6: When `cfg_fixed_only` is 0, a fitting piece of 2 or 3 words is issued as one INCR burst (code 001) with a beat count of 2 or 3.
- R7: When `cfg_fixed_only` is 1, no INCR code is ever emitted. A 2- or 3-word remainder goes out as successive SINGLE requests of one beat each.
- R8: `req_port` equals the `cfg_port` value that was latched at start: 0 selects port 0 and 1 selects port 1.
- R9: `req_burst` uses the AHB codes SINGLE=000, INCR=001, INCR4=011, INCR8=101, INCR16=111, and each defined code comes with its own beat count (1, 4, 8, 16).
- R10: A request holds `req_valid` and all its fields steady until `req_ack`. After an acknowledge, the next request's address is the old address plus 4 bytes per beat, and the transfer ends (`busy` low) once all words have been issued.
- R11: The configuration inputs are sampled only on an accepted `start`. Later changes do not alter the requests of the running transfer.
- R12: No request covers bytes on both sides of a 1 KB address boundary. A burst that would cross it falls back to the next smaller size that fits.
- R13: A `start` pulse while `busy` is high is ignored. The pending request and the running transfer are unaffected, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | ADDR_W | Byte address of the first word (word aligned) |
| start_words | input | LEN_W | Transfer length in 32-bit words |
| cfg_blen | input | 2 | Maximum burst setting / start threshold |
| cfg_fixed_only | input | 1 | 1: only SINGLE and fixed-length bursts |
| cfg_port | input | 1 | Master port select |
| fifo_free | input | FREE_W | Free FIFO entries in words |
| req_valid | output | 1 | Request pending |
| req_burst | output | 3 | HBURST code of the request |
| req_beats | output | 5 | Number of beats in the request |
| req_addr | output | ADDR_W | Byte address of the first beat |
| req_port | output | 1 | Master port for the request |
| req_ack | input | 1 | Bus side accepted the request |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit lengths, a 6-bit free count and a 1 KB boundary. A free count of up to 63 lets every burst size through, and it can also be held just under each threshold. With the 1 KB boundary, a start offset of a few words below it forces the boundary fallback within a short transfer. The 16-bit length allows multi-burst transfers that walk through every size and both remainder modes.

// File: rtl/bplan_pkg.sv
package bplan_pkg;

    localparam int BEAT_W = 5;

    typedef enum logic [2:0] {
        HB_SINGLE = 3'b000,
        HB_INCR   = 3'b001,
        HB_INCR4  = 3'b011,
        HB_INCR8  = 3'b101,
        HB_INCR16 = 3'b111
    } hburst_e;

    typedef enum logic [1:0] {
        BL_ONE     = 2'd0,
        BL_FOUR    = 2'd1,
        BL_EIGHT   = 2'd2,
        BL_SIXTEEN = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAN = 2'd1,
        ST_REQ  = 2'd2
    } state_e;

    typedef struct packed {
        blen_e blen;
        logic  fixed_only;
        logic  port;
    } cfg_t;

    typedef struct packed {
        hburst_e            burst;
        logic [BEAT_W-1:0]  beats;
    } pick_t;

    // Start threshold in words for a burst setting.
    function automatic logic [BEAT_W-1:0] blen_words(blen_e b);
        case (b)
            BL_ONE:     return BEAT_W'(1);
            BL_FOUR:    return BEAT_W'(4);
            BL_EIGHT:   return BEAT_W'(8);
            default:    return BEAT_W'(16);
        endcase
    endfunction

    // Beat count implied by a defined-length code; 0 for INCR.
    function automatic logic [BEAT_W-1:0] code_beats(hburst_e h);
        case (h)
            HB_SINGLE: return BEAT_W'(1);
            HB_INCR4:  return BEAT_W'(4);
            HB_INCR8:  return BEAT_W'(8);
            HB_INCR16: return BEAT_W'(16);
            default:   return BEAT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/bp_cfg_latch.sv
module bp_cfg_latch
    import bplan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{blen: BL_ONE, fixed_only: 1'b0, port: 1'b0};
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/bp_start_gate.sv
module bp_start_gate
    import bplan_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int FREE_W = 6
) (
    input  logic [LEN_W-1:0]  rem_words,
    input  logic [FREE_W-1:0] free_words,
    input  blen_e             blen,
    output logic              go
);

    localparam int CMP_W = (LEN_W > FREE_W ? LEN_W : FREE_W) + 1;

    logic [CMP_W-1:0] thr_x;
    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] need_x;

    always_comb begin
        thr_x  = CMP_W'(blen_words(blen));
        rem_x  = CMP_W'(rem_words);
        free_x = CMP_W'(free_words);
        // A short tail lowers the bar to what is left.
        need_x = (rem_x < thr_x) ? rem_x : thr_x;
        go     = (need_x != '0) && (free_x >= need_x);
    end

endmodule

// File: rtl/bp_size_select.sv
module bp_size_select
    import bplan_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int FREE_W    = 6,
    parameter int BND_BYTES = 1024
) (
    input  logic [$clog2(BND_BYTES)-1:0] addr_off,
    input  logic [LEN_W-1:0]             rem_words,
    input  logic [FREE_W-1:0]            free_words,
    input  cfg_t                         cfg,
    output pick_t                        pick
);

    localparam int BND_W = $clog2(BND_BYTES);
    localparam int CMP_W = 32;

    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] bnd_x;
    logic [CMP_W-1:0] avail;
    logic [CMP_W-1:0] tmp;

    // Per-size permission derived from the burst setting.
    logic allow16;
    logic allow8;
    logic allow4;

    always_comb begin
        rem_x  = CMP_W'(rem_words);
        free_x = CMP_W'(free_words);
        bnd_x  = (CMP_W'(BND_BYTES) - CMP_W'(addr_off)) >> 2;
        tmp    = (rem_x < free_x) ? rem_x : free_x;
        avail  = (tmp < bnd_x) ? tmp : bnd_x;
    end

    always_comb begin
        allow16 = (cfg.blen == BL_SIXTEEN);
        allow8  = (cfg.blen == BL_EIGHT) || allow16;
        allow4  = (cfg.blen == BL_FOUR) || allow8;
    end

    always_comb begin
        if (allow16 && avail >= CMP_W'(16)) begin
            pick = '{burst: HB_INCR16, beats: BEAT_W'(16)};
        end else if (allow8 && avail >= CMP_W'(8)) begin
            pick = '{burst: HB_INCR8, beats: BEAT_W'(8)};
        end else if (allow4 && avail >= CMP_W'(4)) begin
            pick = '{burst: HB_INCR4, beats: BEAT_W'(4)};
        end else if (!cfg.fixed_only && avail >= CMP_W'(2)) begin
            pick = '{burst: HB_INCR,
                     beats: (avail >= CMP_W'(3)) ? BEAT_W'(3) : BEAT_W'(2)};
        end else begin
            pick = '{burst: HB_SINGLE, beats: BEAT_W'(1)};
        end
    end

    if (BND_W < 4) begin : g_bnd_chk
        initial $error("boundary must hold at least one INCR4");
    end

endmodule

// File: rtl/ahb_burst_planner.sv
module ahb_burst_planner
    import bplan_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int FREE_W    = 6,
    parameter int BND_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_words,
    input  logic [1:0]        cfg_blen,
    input  logic              cfg_fixed_only,
    input  logic              cfg_port,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              req_valid,
    output logic [2:0]        req_burst,
    output logic [4:0]        req_beats,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_port,
    input  logic              req_ack,
    output logic              busy
);

    localparam int BND_W = $clog2(BND_BYTES);

    state_e            state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem_words;
    cfg_t              cfg_q;
    cfg_t              cfg_in;
    pick_t             pick;
    pick_t             held;
    logic              go;
    logic              accept;

    assign accept = (state == ST_IDLE) && start && (start_words != '0);

    always_comb begin
        cfg_in.blen       = blen_e'(cfg_blen);
        cfg_in.fixed_only = cfg_fixed_only;
        cfg_in.port       = cfg_port;
    end

    bp_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    bp_start_gate #(
        .LEN_W  (LEN_W),
        .FREE_W (FREE_W)
    ) u_gate (
        .rem_words  (rem_words),
        .free_words (fifo_free),
        .blen       (cfg_q.blen),
        .go         (go)
    );

    bp_size_select #(
        .LEN_W     (LEN_W),
        .FREE_W    (FREE_W),
        .BND_BYTES (BND_BYTES)
    ) u_size (
        .addr_off   (cur_addr[BND_W-1:0]),
        .rem_words  (rem_words),
        .free_words (fifo_free),
        .cfg        (cfg_q),
        .pick       (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            rem_words <= '0;
            held      <= '{burst: HB_SINGLE, beats: '0};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr  <= start_addr;
                        rem_words <= start_words;
                        state     <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (go) begin
                        held  <= pick;
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (req_ack) begin
                        cur_addr  <= cur_addr + (ADDR_W'(held.beats) << 2);
                        rem_words <= rem_words - LEN_W'(held.beats);
                        state     <= (rem_words == LEN_W'(held.beats)) ? ST_IDLE : ST_PLAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_valid = (state == ST_REQ);
    assign req_burst = held.burst;
    assign req_beats = held.beats;
    assign req_addr  = cur_addr;
    assign req_port  = cfg_q.port;
    assign busy      = (state != ST_IDLE);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_burst) && $stable(req_beats) && $stable(req_addr))); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack) |=> (req_addr == $past(req_addr) + (ADDR_W'($past(req_beats)) << 2))); // R10

    AST_NO_INCR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_q.fixed_only) |-> (req_burst != HB_INCR)); // R7

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((32'(req_addr[BND_W-1:0]) + 32'(req_beats) * 4) <= 32'(BND_BYTES))); // R12

    AST_MAX_SIZE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst == HB_INCR16) |-> (cfg_q.blen == BL_SIXTEEN)); // R5

    AST_CODE_BEATS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst != HB_INCR) |-> (req_beats == code_beats(hburst_e'(req_burst)))); // R9

    AST_INCR_LEN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_burst == HB_INCR) |-> (req_beats == 5'd2 || req_beats == 5'd3)); // R6

    AST_FIT_FREE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> (32'(req_beats) <= 32'($past(fifo_free)))); // R4

endmodule

// File: tb/ahb_burst_planner_tb_top.sv
`timescale 1ns/1ps
module ahb_burst_planner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] start_words = '0;
    logic [1:0]  cfg_blen = '0;
    logic        cfg_fixed_only = 1'b0;
    logic        cfg_port = 1'b0;
    logic [5:0]  fifo_free = 6'd63;
    logic        req_ack = 1'b0;
    logic        req_valid;
    logic [2:0]  req_burst;
    logic [4:0]  req_beats;
    logic [31:0] req_addr;
    logic        req_port;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ahb_burst_planner dut_i (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .start_addr     (start_addr),
        .start_words    (start_words),
        .cfg_blen       (cfg_blen),
        .cfg_fixed_only (cfg_fixed_only),
        .cfg_port       (cfg_port),
        .fifo_free      (fifo_free),
        .req_valid      (req_valid),
        .req_burst      (req_burst),
        .req_beats      (req_beats),
        .req_addr       (req_addr),
        .req_port       (req_port),
        .req_ack        (req_ack),
        .busy           (busy)
    );

    localparam logic [2:0] C_SINGLE = 3'b000;
    localparam logic [2:0] C_INCR   = 3'b001;
    localparam logic [2:0] C_INCR4  = 3'b011;
    localparam logic [2:0] C_INCR8  = 3'b101;
    localparam logic [2:0] C_INCR16 = 3'b111;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic kick(logic [31:0] a, logic [15:0] w, logic [1:0] bl,
                        logic fx, logic pt);
        @(negedge clk);
        start_addr = a; start_words = w;
        cfg_blen = bl; cfg_fixed_only = fx; cfg_port = pt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_req(string tag, logic [2:0] b, logic [4:0] n,
                              logic [31:0] a, logic pt);
        @(negedge clk);
        check({tag, " valid"}, 32'(req_valid), 1);
        check({tag, " burst"}, 32'(req_burst), 32'(b));
        check({tag, " beats"}, 32'(req_beats), 32'(n));
        check({tag, " addr"},  req_addr, a);
        check({tag, " port"},  32'(req_port), 32'(pt));
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic expect_none(string tag, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " no request"}, 32'(req_valid), 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 valid", 32'(req_valid), 0);
        check("R1 port", 32'(req_port), 0);
    endtask

    task automatic t_big_bursts();
        fifo_free = 6'd63;
        kick(32'h1000, 16'd40, 2'd3, 1'b0, 1'b0);
        expect_req("R4 R9 first", C_INCR16, 5'd16, 32'h1000, 1'b0);
        expect_req("R10 second", C_INCR16, 5'd16, 32'h1040, 1'b0);
        expect_req("R4 tail8", C_INCR8, 5'd8, 32'h1080, 1'b0);
        check("R10 done", 32'(busy), 0);
    endtask

    task automatic t_incr_tail();
        fifo_free = 6'd63;
        kick(32'h2000, 16'd7, 2'd1, 1'b0, 1'b1);
        expect_req("R5 R8 incr4", C_INCR4, 5'd4, 32'h2000, 1'b1);
        expect_req("R6 incr3", C_INCR, 5'd3, 32'h2010, 1'b1);
        check("R10 done", 32'(busy), 0);
    endtask

    task automatic t_fixed_tail();
        fifo_free = 6'd63;
        kick(32'h3000, 16'd6, 2'd1, 1'b1, 1'b0);
        expect_req("R7 incr4", C_INCR4, 5'd4, 32'h3000, 1'b0);
        expect_req("R7 single a", C_SINGLE, 5'd1, 32'h3010, 1'b0);
        expect_req("R7 single b", C_SINGLE, 5'd1, 32'h3014, 1'b0);
        check("R7 done", 32'(busy), 0);
    endtask

    task automatic t_threshold();
        fifo_free = 6'd7;
        kick(32'h4000, 16'd20, 2'd2, 1'b0, 1'b0);
        expect_none("R2 below eight", 3);
        fifo_free = 6'd8;
        expect_req("R2 at eight", C_INCR8, 5'd8, 32'h4000, 1'b0);
        expect_req("R2 again", C_INCR8, 5'd8, 32'h4020, 1'b0);
        expect_req("R3 R4 rest", C_INCR4, 5'd4, 32'h4040, 1'b0);
        check("R2 done", 32'(busy), 0);
        fifo_free = 6'd63;
    endtask

    task automatic t_short_tail();
        fifo_free = 6'd2;
        kick(32'h5000, 16'd3, 2'd3, 1'b0, 1'b0);
        expect_none("R3 two free", 2);
        fifo_free = 6'd3;
        expect_req("R3 tail", C_INCR, 5'd3, 32'h5000, 1'b0);
        check("R3 done", 32'(busy), 0);
        fifo_free = 6'd63;
    endtask

    task automatic t_boundary();
        fifo_free = 6'd63;
        kick(32'h03F0, 16'd20, 2'd3, 1'b0, 1'b0);
        expect_req("R12 fallback", C_INCR4, 5'd4, 32'h03F0, 1'b0);
        expect_req("R12 after", C_INCR16, 5'd16, 32'h0400, 1'b0);
        check("R12 done", 32'(busy), 0);
    endtask

    task automatic t_cfg_sample();
        fifo_free = 6'd63;
        kick(32'h6000, 16'd32, 2'd3, 1'b0, 1'b0);
        cfg_blen = 2'd0; cfg_port = 1'b1; cfg_fixed_only = 1'b1;
        expect_req("R11 first", C_INCR16, 5'd16, 32'h6000, 1'b0);
        expect_req("R11 second", C_INCR16, 5'd16, 32'h6040, 1'b0);
        check("R11 done", 32'(busy), 0);
    endtask

    task automatic t_busy_start();
        fifo_free = 6'd63;
        kick(32'h0200, 16'd4, 2'd1, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 valid", 32'(req_valid), 1);
        start_addr = 32'h0800; start_words = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R13 held valid", 32'(req_valid), 1);
        check("R13 held addr", req_addr, 32'h0200);
        @(negedge clk);
        check("R10 held burst", 32'(req_burst), 32'(C_INCR4));
        check("R10 held beats", 32'(req_beats), 4);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        check("R13 idle", 32'(busy), 0);
        expect_none("R13 no second", 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_big_bursts();
        t_incr_tail();
        t_fixed_tail();
        t_threshold();
        t_short_tail();
        t_boundary();
        t_cfg_sample();
        t_busy_start();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule